// File: doc/BRIEF.md
# Multi-width overlaid register file

This block is a small register file whose single byte store can be read and written as 8-bit, 16-bit or 32-bit registers. Byte registers, word registers and dword registers all reach into the same bytes, so a write through one view shows up at once through every overlapping register of the other views. Multi-byte registers are big-endian: the most significant byte sits at the lowest byte position.

There is one write port and one read port. The write port takes a register index, an access width, a write mode and a step code. The mode selects a plain write, a load of a 16-bit immediate into a dword, or an increment or decrement by 1, 2 or 4. The read port takes an index and a width and returns the register right-aligned in a 32-bit result with zeros above it. Any illegal combination on either port raises an error flag. A rejected write changes nothing. A rejected read returns zero.

Storage is 40 bytes. Bytes 0 to 31 sit behind the byte and word registers and the low dword registers. Bytes 32 to 39 sit behind the two high dword registers only.

Top module: `mwrf_top`

## Requirements
- R1: Width code 0 selects a byte register. Index n in 0..15 maps to storage byte n. Indices 16..63 are rejected with `wr_err` or `rd_err` raised.
- R2: Width code 1 selects a word register. Legal indices are the even values 0..30. Word k reads as {byte k, byte k+1}. Odd indices and indices above 30 are rejected.
- R3: Width code 2 selects a dword register. Legal indices are 0, 4, ..., 28, which read as {byte k .. byte k+3}, and 56 and 60, which map onto storage bytes 32..35 and 36..39. Those bytes are not reachable from any other index. Every other dword index is rejected.
- R4: An accepted write changes only the bytes of the addressed register. A cycle with `wr_en` low changes nothing.
- R5: Mode 3 (dword only) writes `wr_data[15:0]` into the upper half of the dword and leaves the lower half unchanged.
- R6: Mode 4 (dword only) writes `wr_data[15:0]` into the lower half and zeros into the upper half. Mode 5 (dword only) writes `wr_data[15:0]` into the lower half and all ones into the upper half.
- R7: Mode 6 (dword only) writes `wr_data[15:0]` into the lower half and copies `wr_data[15]` into all of the upper half.
- R8: Mode 1 increments and mode 2 decrements the register by a step. Step code 0 means 1, code 1 means 2 and code 2 means 4. The result wraps modulo the access width.
- R9: A write is rejected, with `wr_err` raised and storage left unchanged, in each of these cases: its index is illegal for its width; width code 3 is used; mode 7 is used; modes 3..6 are used with a byte or word width; or step code 3 is used with mode 1 or 2. Mode 0 is a plain write of the low bits of `wr_data`.
- R10: Reads are combinational and show the state before the next rising edge. A rejected read returns 0.
- R11: A synchronous active-high reset clears every storage byte to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_width | input | 2 | Write width code: 0 byte, 1 word, 2 dword |
| wr_mode | input | 3 | Write mode code |
| wr_step | input | 2 | Step code for increment and decrement |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | The current write request is rejected |
| rd_idx | input | 6 | Read register index |
| rd_width | input | 2 | Read width code |
| rd_data | output | 32 | Read value, right-aligned and zero-padded |
| rd_err | output | 1 | The current read request is illegal |

## Verification
A wrong internal state shows up only through the read port. Because reads are combinational, a corrupted or misplaced byte is visible in the cycle right after the faulty edge, on any register view that covers that byte. For that reason the checks read back the written register after every write, then sweep all byte positions and both high dwords. This catches writes that spill into neighbouring bytes and aliasing into the separate high bank. Rejected writes are followed by reads that would expose any partial update.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

    localparam int IDX_W       = 6;
    localparam int DATA_W      = 32;
    localparam int BYTE_REGS   = 16;
    localparam int MAIN_BYTES  = 32;
    localparam int EXTRA_BYTES = 8;
    localparam int NBYTES      = MAIN_BYTES + EXTRA_BYTES;
    localparam int HI_DW_A     = 56;
    localparam int HI_DW_B     = 60;
    localparam int NB_W        = 3;

    typedef enum logic [1:0] {
        WD_BYTE  = 2'd0,
        WD_WORD  = 2'd1,
        WD_DWORD = 2'd2,
        WD_BAD   = 2'd3
    } width_e;

    typedef enum logic [2:0] {
        MD_PLAIN     = 3'd0,
        MD_INC       = 3'd1,
        MD_DEC       = 3'd2,
        MD_HI16      = 3'd3,
        MD_LO16_ZERO = 3'd4,
        MD_LO16_ONES = 3'd5,
        MD_LO16_SEXT = 3'd6,
        MD_BAD       = 3'd7
    } mode_e;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] base;
        logic [NB_W-1:0]  nbytes;
    } loc_t;

    function automatic logic [NB_W-1:0] width_bytes(width_e w);
        case (w)
            WD_BYTE:  return NB_W'(1);
            WD_WORD:  return NB_W'(2);
            WD_DWORD: return NB_W'(4);
            default:  return NB_W'(0);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(width_e w);
        case (w)
            WD_BYTE:  return DATA_W'(32'h0000_00FF);
            WD_WORD:  return DATA_W'(32'h0000_FFFF);
            WD_DWORD: return DATA_W'(32'hFFFF_FFFF);
            default:  return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] step_value(logic [1:0] code);
        case (code)
            2'd0:    return DATA_W'(1);
            2'd1:    return DATA_W'(2);
            2'd2:    return DATA_W'(4);
            default: return '0;
        endcase
    endfunction

    function automatic loc_t locate(logic [IDX_W-1:0] idx, width_e w);
        loc_t r;
        r.ok     = 1'b0;
        r.base   = idx;
        r.nbytes = width_bytes(w);
        case (w)
            WD_BYTE:  r.ok = (int'(idx) < BYTE_REGS);
            WD_WORD:  r.ok = (idx[0] == 1'b0) && (int'(idx) < MAIN_BYTES);
            WD_DWORD: begin
                if (idx[1:0] == 2'b00 && int'(idx) < MAIN_BYTES) begin
                    r.ok = 1'b1;
                end else if (int'(idx) == HI_DW_A) begin
                    r.ok   = 1'b1;
                    r.base = IDX_W'(MAIN_BYTES);
                end else if (int'(idx) == HI_DW_B) begin
                    r.ok   = 1'b1;
                    r.base = IDX_W'(MAIN_BYTES + 4);
                end
            end
            default:  r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mwrf_locate.sv
module mwrf_locate
    import mwrf_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [IW-1:0] idx,
    input  logic [1:0]    width,
    output loc_t          loc
);
    always_comb begin
        loc = locate(IDX_W'(idx), width_e'(width));
    end
endmodule

// File: rtl/mwrf_update.sv
module mwrf_update
    import mwrf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          loc_ok,
    input  logic [1:0]    width,
    input  logic [2:0]    mode,
    input  logic [1:0]    step,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] new_val,
    output logic          reject
);
    localparam int HALF = DW / 2;

    width_e w;
    mode_e  m;
    logic   imm_mode;
    logic   arith_mode;
    logic [DW-1:0] mask;

    always_comb begin
        w          = width_e'(width);
        m          = mode_e'(mode);
        mask       = width_mask(w);
        imm_mode   = (m == MD_HI16) || (m == MD_LO16_ZERO) ||
                     (m == MD_LO16_ONES) || (m == MD_LO16_SEXT);
        arith_mode = (m == MD_INC) || (m == MD_DEC);

        reject = !loc_ok || (m == MD_BAD) ||
                 (imm_mode && w != WD_DWORD) ||
                 (arith_mode && step == 2'd3);

        case (m)
            MD_INC:       new_val = (old_val + step_value(step)) & mask;
            MD_DEC:       new_val = (old_val - step_value(step)) & mask;
            MD_HI16:      new_val = {data[HALF-1:0], old_val[HALF-1:0]};
            MD_LO16_ZERO: new_val = {{HALF{1'b0}}, data[HALF-1:0]};
            MD_LO16_ONES: new_val = {{HALF{1'b1}}, data[HALF-1:0]};
            MD_LO16_SEXT: new_val = {{HALF{data[HALF-1]}}, data[HALF-1:0]};
            default:      new_val = data & mask;
        endcase
    end
endmodule

// File: rtl/mwrf_store.sv
module mwrf_store
    import mwrf_pkg::*;
#(
    parameter int NB  = NBYTES,
    parameter int NRD = 2,
    parameter int DW  = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  wbase,
    input  logic [NB_W-1:0]   wnb,
    input  logic [DW-1:0]     wval,
    input  logic [IDX_W-1:0]  rbase [NRD],
    input  logic [NB_W-1:0]   rnb   [NRD],
    output logic [DW-1:0]     rval  [NRD],
    output logic [NB*8-1:0]   mem_flat
);
    localparam int MAXB = DW / 8;

    logic [7:0]    mem   [NB];
    logic [NB-1:0] hit;
    logic [7:0]    nbyte [NB];

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            int off;
            off      = i - int'(wbase);
            hit[i]   = we && (off >= 0) && (off < int'(wnb));
            nbyte[i] = '0;
            if (hit[i]) begin
                nbyte[i] = 8'(wval >> (8 * (int'(wnb) - 1 - off)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (hit[i]) mem[i] <= nbyte[i];
            end
        end
    end

    genvar p, b;
    generate
        for (p = 0; p < NRD; p++) begin : g_rd
            always_comb begin
                rval[p] = '0;
                for (int j = 0; j < MAXB; j++) begin
                    if (j < int'(rnb[p]) && (int'(rbase[p]) + j) < NB) begin
                        rval[p] = {rval[p][DW-9:0], mem[int'(rbase[p]) + j]};
                    end
                end
            end
        end
        for (b = 0; b < NB; b++) begin : g_flat
            assign mem_flat[8*b +: 8] = mem[b];
        end
    endgenerate
endmodule

// File: rtl/mwrf_top.sv
module mwrf_top
    import mwrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [5:0]  wr_idx,
    input  logic [1:0]  wr_width,
    input  logic [2:0]  wr_mode,
    input  logic [1:0]  wr_step,
    input  logic [31:0] wr_data,
    output logic        wr_err,
    input  logic [5:0]  rd_idx,
    input  logic [1:0]  rd_width,
    output logic [31:0] rd_data,
    output logic        rd_err
);
    localparam int PORT_OLD = 0;
    localparam int PORT_RD  = 1;
    localparam int NRD      = 2;

    loc_t loc_w, loc_r;
    logic [IDX_W-1:0]    rbase [NRD];
    logic [NB_W-1:0]     rnb   [NRD];
    logic [DATA_W-1:0]   rval  [NRD];
    logic [DATA_W-1:0]   new_val;
    logic                reject;
    logic                commit;
    logic [NBYTES*8-1:0] mem_flat;

    mwrf_locate u_wloc (.idx(wr_idx), .width(wr_width), .loc(loc_w));
    mwrf_locate u_rloc (.idx(rd_idx), .width(rd_width), .loc(loc_r));

    always_comb begin
        rbase[PORT_OLD] = loc_w.base;
        rnb[PORT_OLD]   = loc_w.nbytes;
        rbase[PORT_RD]  = loc_r.base;
        rnb[PORT_RD]    = loc_r.nbytes;
    end

    mwrf_update u_upd (
        .loc_ok  (loc_w.ok),
        .width   (wr_width),
        .mode    (wr_mode),
        .step    (wr_step),
        .old_val (rval[PORT_OLD]),
        .data    (wr_data),
        .new_val (new_val),
        .reject  (reject)
    );

    assign commit = wr_en && !reject;
    assign wr_err = wr_en && reject;

    mwrf_store #(.NB(NBYTES), .NRD(NRD)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (commit),
        .wbase    (loc_w.base),
        .wnb      (loc_w.nbytes),
        .wval     (new_val),
        .rbase    (rbase),
        .rnb      (rnb),
        .rval     (rval),
        .mem_flat (mem_flat)
    );

    assign rd_err  = !loc_r.ok;
    assign rd_data = loc_r.ok ? rval[PORT_RD] : '0;
endmodule

// File: rtl/mwrf_chk.sv
module mwrf_chk
    import mwrf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                wr_err,
    input logic [2:0]          wr_mode,
    input logic [1:0]          wr_step,
    input logic                rd_err,
    input logic [31:0]         rd_data,
    input logic [NBYTES*8-1:0] mem_flat
);
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (mem_flat == '0));

    assert_rejected_write_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_err) |=> $stable(mem_flat));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_flat));

    assert_bad_step_flagged_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_mode == 3'd1 || wr_mode == 3'd2) && wr_step == 2'd3) |-> wr_err);

    assert_bad_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == '0));
endmodule

bind mwrf_top mwrf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_err   (wr_err),
    .wr_mode  (wr_mode),
    .wr_step  (wr_step),
    .rd_err   (rd_err),
    .rd_data  (rd_data),
    .mem_flat (mem_flat)
);

// File: tb/tb_mwrf_top.sv
module tb_mwrf_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [1:0]  wr_width = '0;
    logic [2:0]  wr_mode = '0;
    logic [1:0]  wr_step = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic [5:0]  rd_idx = '0;
    logic [1:0]  rd_width = '0;
    logic [31:0] rd_data;
    logic        rd_err;

    int total = 0;
    int bad   = 0;
    logic [7:0] mb [40];

    always #10 clk = ~clk;

    mwrf_top dut (.*);

    typedef struct packed {
        logic [5:0]  idx;
        logic [1:0]  w;
        logic [2:0]  mode;
        logic [1:0]  step;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  2'd0, 3'd0, 2'd0, 32'h0000_00A5},
        '{6'd2,  2'd1, 3'd0, 2'd0, 32'h0000_1234},
        '{6'd4,  2'd2, 3'd0, 2'd0, 32'hDEAD_BEEF},
        '{6'd4,  2'd2, 3'd3, 2'd0, 32'h0000_CAFE},
        '{6'd8,  2'd2, 3'd4, 2'd0, 32'h5555_8001},
        '{6'd12, 2'd2, 3'd5, 2'd0, 32'h0000_0042},
        '{6'd16, 2'd2, 3'd6, 2'd0, 32'h0000_8000},
        '{6'd20, 2'd2, 3'd6, 2'd0, 32'hFFFF_7FFF},
        '{6'd5,  2'd0, 3'd1, 2'd1, 32'h0},
        '{6'd6,  2'd1, 3'd2, 2'd2, 32'h0},
        '{6'd56, 2'd2, 3'd0, 2'd0, 32'h1122_3344},
        '{6'd60, 2'd2, 3'd1, 2'd0, 32'h0},
        '{6'd0,  2'd2, 3'd2, 2'd0, 32'h0},
        '{6'd30, 2'd1, 3'd0, 2'd0, 32'h0000_FFFF},
        '{6'd30, 2'd1, 3'd1, 2'd0, 32'h0},
        '{6'd15, 2'd0, 3'd2, 2'd2, 32'h0},
        '{6'd32, 2'd2, 3'd0, 2'd0, 32'h7777_7777},
        '{6'd16, 2'd0, 3'd0, 2'd0, 32'h0000_0066},
        '{6'd3,  2'd1, 3'd0, 2'd0, 32'h0000_9999},
        '{6'd8,  2'd2, 3'd1, 2'd3, 32'h0},
        '{6'd2,  2'd1, 3'd3, 2'd0, 32'h0000_ABCD},
        '{6'd4,  2'd2, 3'd7, 2'd0, 32'h0123_4567}
    };

    function automatic int tb_base(int idx, int w);
        if (w == 0) return (idx < 16) ? idx : -1;
        if (w == 1) return (idx % 2 == 0 && idx <= 30) ? idx : -1;
        if (w == 2) begin
            if (idx % 4 == 0 && idx <= 28) return idx;
            if (idx == 56) return 32;
            if (idx == 60) return 36;
        end
        return -1;
    endfunction

    function automatic logic [31:0] tb_get(int base, int nb);
        logic [31:0] v = '0;
        for (int j = 0; j < nb; j++) v = (v << 8) | 32'(mb[base + j]);
        return v;
    endfunction

    function automatic bit tb_reject(int idx, int w, int mode, int step);
        if (tb_base(idx, w) < 0) return 1;
        if (mode == 7) return 1;
        if (mode >= 3 && w != 2) return 1;
        if ((mode == 1 || mode == 2) && step == 3) return 1;
        return 0;
    endfunction

    function automatic string tag_of(int idx, int w, int mode, int step);
        if (tb_reject(idx, w, mode, step)) return "R9";
        if (mode == 3) return "R5";
        if (mode == 4 || mode == 5) return "R6";
        if (mode == 6) return "R7";
        if (mode == 1 || mode == 2) return "R8";
        if (w == 0) return "R1";
        if (w == 1) return "R2";
        return "R3";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(int idx, int w, int mode, int step, logic [31:0] d);
        int base = tb_base(idx, w);
        int nb   = 1 << w;
        logic [31:0] old = tb_get(base, nb);
        logic [31:0] msk = (w == 2) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
        logic [31:0] stp = (step == 0) ? 1 : (step == 1) ? 2 : 4;
        logic [31:0] nv;
        case (mode)
            1: nv = (old + stp) & msk;
            2: nv = (old - stp) & msk;
            3: nv = {d[15:0], old[15:0]};
            4: nv = {16'h0000, d[15:0]};
            5: nv = {16'hFFFF, d[15:0]};
            6: nv = {{16{d[15]}}, d[15:0]};
            default: nv = d & msk;
        endcase
        for (int j = 0; j < nb; j++) mb[base + j] = 8'(nv >> (8 * (nb - 1 - j)));
    endtask

    task automatic do_write(int idx, int w, int mode, int step, logic [31:0] d);
        bit    rej = tb_reject(idx, w, mode, step);
        string tg  = tag_of(idx, w, mode, step);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_width = 2'(w);
        wr_mode = 3'(mode); wr_step = 2'(step); wr_data = d;
        #1 check(tg, 32'(wr_err), 32'(rej));
        @(posedge clk);
        if (!rej) model_write(idx, w, mode, step, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(int idx, int w, string req);
        int base = tb_base(idx, w);
        @(negedge clk);
        rd_idx = 6'(idx); rd_width = 2'(w);
        #1;
        check(req, 32'(rd_err), 32'(base < 0));
        check(req, rd_data, (base < 0) ? 32'h0 : tb_get(base, 1 << w));
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 40; i++) mb[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11: reset state
        do_read(0, 2, "R11");
        do_read(56, 2, "R11");
        do_read(30, 1, "R11");

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            do_write(int'(VECS[v].idx), int'(VECS[v].w), int'(VECS[v].mode),
                     int'(VECS[v].step), VECS[v].data);
            if (tb_base(int'(VECS[v].idx), int'(VECS[v].w)) >= 0)
                do_read(int'(VECS[v].idx), int'(VECS[v].w), tag_of(int'(VECS[v].idx),
                        int'(VECS[v].w), int'(VECS[v].mode), int'(VECS[v].step)));
        end

        // R4: full sweep shows no stray byte changed
        for (int i = 0; i < 16; i++) do_read(i, 0, "R4");
        for (int i = 16; i < 32; i += 2) do_read(i, 1, "R4");
        do_read(56, 2, "R4");
        do_read(60, 2, "R4");

        // R3: illegal dword indices are flagged and leave storage unchanged
        do_write(36, 2, 0, 0, 32'hAAAA_AAAA);
        do_write(58, 2, 0, 0, 32'hBBBB_BBBB);
        do_read(36, 2, "R3");
        do_read(2, 2, "R3");
        do_read(56, 2, "R3");
        do_read(28, 2, "R3");

        // R1 / R2: illegal reads return zero with the flag raised
        do_read(20, 0, "R1");
        do_read(7, 1, "R2");
        do_read(0, 3, "R10");

        // R10: the read shows the old value until the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd24; wr_width = 2'd2; wr_mode = 3'd0;
        wr_step = 2'd0; wr_data = 32'h0BAD_F00D;
        rd_idx = 6'd24; rd_width = 2'd2;
        #1 check("R10", rd_data, tb_get(24, 4));
        @(posedge clk);
        model_write(24, 2, 0, 0, 32'h0BAD_F00D);
        #1 check("R10", rd_data, 32'h0BAD_F00D);
        @(negedge clk) wr_en = 1'b0;
        do_read(26, 1, "R10");

        // R8: wraps at the bottom of the dword and at the top of a byte
        do_write(60, 2, 2, 2, 32'h0);
        do_read(60, 2, "R8");
        do_write(1, 0, 0, 0, 32'h0000_00FE);
        do_write(1, 0, 1, 2, 32'h0);
        do_read(1, 0, "R8");
        do_read(0, 1, "R8");

        // R11: reset in the middle of a run
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 40; i++) mb[i] = '0;
        do_read(0, 2, "R11");
        do_read(56, 2, "R11");
        do_read(60, 2, "R11");
        do_read(24, 2, "R11");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule